// File: doc/BRIEF.md
# Interrupt Vector Base Select with Timed Unlock

This block holds the one control bit that places the interrupt vector table either at the bottom of the application region or at the start of the boot region. It turns that bit into a vector base address for the interrupt controller. Software cannot change the bit with a single store. It must first arm the register with a change-enable write. It then has a short fixed window in which to commit the new placement with a second write that leaves change-enable clear.

From the arming write onward, the block masks interrupt acceptance through a dedicated mask output. The processor's global interrupt-enable flag is never touched. If a commit lands, the mask holds until the next instruction has retired. If no commit lands, the mask falls when the window lapses. Independently, two region lock inputs block interrupts when the vector table and the current execution region disagree.

The core, the global interrupt flag and the interrupt controller sit outside this block. They take `sel_o`, `vec_base_o` and `irq_mask_o`. Register writes arrive as a strobe with data. Register reads take `rdata_o`.

Top module: `ivec_reloc`

## Requirements
- R1: After reset, `sel_o` is 0, `vec_base_o` is 0, `rdata_o` is all zero, and `irq_mask_o` is 0 while both lock inputs are low.
- R2: The register uses two fields. Bit 0 is the select bit (1 = boot placement). Bit 1 is the change-enable bit. A write with bit 1 set raises `irq_mask_o` in the same cycle and opens the window. `rdata_o[1]` reads 1 in each of the following WIN_CYC (4) cycles.
- R3: A write with bit 1 clear, made while the window is open, loads bit 0 into `sel_o` from the next cycle on. The same write closes the window, so `rdata_o[1]` reads 0.
- R4: A write with bit 1 clear, made while no window is open, leaves `sel_o` unchanged. This includes a write made one cycle after the window has lapsed.
- R5: With no commit, `irq_mask_o` stays high in the arming cycle and in the WIN_CYC cycles after it. After that `rdata_o[1]` returns to 0 and, with no lock masking, `irq_mask_o` falls.
- R6: After a commit, `irq_mask_o` stays high until an `insn_done_i` pulse arrives in a later cycle. It falls in the cycle after that pulse.
- R7: A write with bit 1 set while the window is open restarts the full WIN_CYC count. Such a write never changes `sel_o`, whatever bit 0 holds.
- R8: While `sel_o` is 1, `lock_boot_i` is 1 and `in_boot_i` is 0, `irq_mask_o` is high.
- R9: While `sel_o` is 0, `lock_app_i` is 1 and `in_boot_i` is 1, `irq_mask_o` is high. No other lock and region combination masks on its own.
- R10: `vec_base_o` equals BOOT_BASE while `sel_o` is 1 and equals 0 while `sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data: bit 0 select, bit 1 change-enable |
| insn_done_i | input | 1 | Pulse when an instruction retires |
| in_boot_i | input | 1 | Current fetch address lies in the boot region |
| lock_app_i | input | 1 | Application-region lock programmed |
| lock_boot_i | input | 1 | Boot-region lock programmed |
| sel_o | output | 1 | Vector placement: 0 application, 1 boot |
| vec_base_o | output | ADDR_W | Vector table base address |
| irq_mask_o | output | 1 | Interrupt acceptance mask |
| rdata_o | output | DATA_W | Register read value |

## Verification
The directed sequences separate four cases by the cycle of the second write: on time, one cycle late, with no window opened at all, and after a restart that pushes the deadline out. Each pins the window edge to an exact cycle. Commit and retire pulses are issued in the same cycle and in later cycles, which tells a mask that releases on the write's own completion apart from one that waits for the following instruction. All eight lock and region combinations are stepped under both placements. Random traffic then mixes arming, commits, double-bit writes and retire pulses at high density, so that restarts, overlapping windows and pending masks meet in orders the directed tests do not reach.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int unsigned SEL_POS = 0;
  localparam int unsigned CE_POS  = 1;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_ARM    = 2'd1,
    OP_COMMIT = 2'd2
  } ivr_op_e;
endpackage

// File: rtl/ivr_op_decode.sv
module ivr_op_decode
  import ivr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              win_open_i,
  output ivr_op_e           op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (wr_en_i) begin
      if (wr_data_i[CE_POS])  op_o = OP_ARM;
      else if (win_open_i)    op_o = OP_COMMIT;
    end
  end
endmodule

// File: rtl/ivr_window.sv
module ivr_window
  import ivr_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ivr_op_e op_i,
  output logic    win_open_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (op_i == OP_ARM)    cnt_q <= CNT_W'(WIN_CYC);
    else if (op_i == OP_COMMIT) cnt_q <= '0;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign win_open_o = (cnt_q != '0);
endmodule

// File: rtl/ivr_sel_reg.sv
module ivr_sel_reg
  import ivr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ivr_op_e op_i,
  input  logic    sel_d_i,
  input  logic    insn_done_i,
  output logic    sel_o,
  output logic    hold_o
);
  logic sel_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (op_i == OP_COMMIT) begin
      sel_q  <= sel_d_i;
      hold_q <= 1'b1;
    end else if (hold_q && insn_done_i) begin
      hold_q <= 1'b0; // instruction after the commit has retired
    end
  end

  assign sel_o  = sel_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/ivr_lock_gate.sv
module ivr_lock_gate (
  input  logic sel_i,
  input  logic in_boot_i,
  input  logic lock_app_i,
  input  logic lock_boot_i,
  output logic lock_mask_o
);
  // vectors and execution in opposite regions, with that region's lock set
  assign lock_mask_o = ( sel_i && lock_boot_i && !in_boot_i) ||
                       (!sel_i && lock_app_i  &&  in_boot_i);
endmodule

// File: rtl/ivec_reloc.sv
module ivec_reloc
  import ivr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_CYC   = 4,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              insn_done_i,
  input  logic              in_boot_i,
  input  logic              lock_app_i,
  input  logic              lock_boot_i,
  output logic              sel_o,
  output logic [ADDR_W-1:0] vec_base_o,
  output logic              irq_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  ivr_op_e op;
  logic    win_open, hold, lock_mask;

  ivr_op_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .win_open_i (win_open),
    .op_o       (op)
  );

  ivr_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .win_open_o (win_open)
  );

  ivr_sel_reg u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .sel_d_i     (wr_data_i[SEL_POS]),
    .insn_done_i (insn_done_i),
    .sel_o       (sel_o),
    .hold_o      (hold)
  );

  ivr_lock_gate u_lock (
    .sel_i       (sel_o),
    .in_boot_i   (in_boot_i),
    .lock_app_i  (lock_app_i),
    .lock_boot_i (lock_boot_i),
    .lock_mask_o (lock_mask)
  );

  assign irq_mask_o = (op == OP_ARM) || win_open || hold || lock_mask;
  assign vec_base_o = sel_o ? BOOT_BASE : '0;

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == SEL_POS)     begin : g_sel assign rdata_o[b] = sel_o;    end
    else if (b == CE_POS) begin : g_ce  assign rdata_o[b] = win_open; end
    else                  begin : g_z   assign rdata_o[b] = 1'b0;     end
  end
endmodule

// File: rtl/ivec_reloc_chk.sv
module ivec_reloc_chk
  import ivr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              insn_done_i,
  input logic              in_boot_i,
  input logic              lock_app_i,
  input logic              lock_boot_i,
  input logic              sel_o,
  input logic [ADDR_W-1:0] vec_base_o,
  input logic              irq_mask_o,
  input logic [DATA_W-1:0] rdata_o
);
  p_mask_on_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[CE_POS] |-> irq_mask_o);

  p_window_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[CE_POS] |=> rdata_o[CE_POS]);

  p_commit_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[CE_POS] && rdata_o[CE_POS] |=> !rdata_o[CE_POS] && irq_mask_o);

  p_sel_only_in_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> $past(wr_en_i && !wr_data_i[CE_POS] && rdata_o[CE_POS]));

  p_mask_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[CE_POS] |-> irq_mask_o);

  p_arm_keeps_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[CE_POS] |=> $stable(sel_o));

  p_boot_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o && lock_boot_i && !in_boot_i |-> irq_mask_o);

  p_app_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o && lock_app_i && in_boot_i |-> irq_mask_o);

  p_base_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_base_o == (sel_o ? BOOT_BASE : '0));
endmodule

bind ivec_reloc ivec_reloc_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)
) u_chk (.*);

// File: tb/ivec_reloc_tb.sv
`timescale 1ns/1ps
module ivec_reloc_tb;
  import ivr_pkg::*;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned WIN_CYC = 4;
  localparam logic [ADDR_W-1:0] BOOT_BASE = 16'h3800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, done = 1'b0, boot = 1'b0, l_app = 1'b0, l_boot = 1'b0;
  logic [DATA_W-1:0] wdat = '0;
  logic sel;
  logic [ADDR_W-1:0] vbase;
  logic mask;
  logic [DATA_W-1:0] rdat;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ivec_reloc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC), .BOOT_BASE(BOOT_BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdat),
    .insn_done_i(done), .in_boot_i(boot), .lock_app_i(l_app), .lock_boot_i(l_boot),
    .sel_o(sel), .vec_base_o(vbase), .irq_mask_o(mask), .rdata_o(rdat)
  );

  // reference state, built from the requirements
  logic m_sel = 1'b0, m_hold = 1'b0;
  int   m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 1'b0; m_hold <= 1'b0; m_cnt <= 0;
    end else if (wr_en && wdat[CE_POS]) begin
      m_cnt <= WIN_CYC;
      if (m_hold && done) m_hold <= 1'b0;
    end else if (wr_en && m_cnt != 0) begin
      m_sel <= wdat[SEL_POS]; m_cnt <= 0; m_hold <= 1'b1;
    end else begin
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      if (m_hold && done) m_hold <= 1'b0;
    end
  end

  function automatic logic exp_mask();
    return (wr_en && wdat[CE_POS]) || (m_cnt != 0) || m_hold ||
           (m_sel && l_boot && !boot) || (!m_sel && l_app && boot);
  endfunction

  function automatic logic [DATA_W-1:0] exp_rdata();
    logic [DATA_W-1:0] r = '0;
    r[SEL_POS] = m_sel;
    r[CE_POS]  = (m_cnt != 0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk({tag, " sel"},   32'(sel),   32'(m_sel));
    chk({tag, " base"},  32'(vbase), 32'(m_sel ? BOOT_BASE : '0));
    chk({tag, " mask"},  32'(mask),  32'(exp_mask()));
    chk({tag, " rdata"}, 32'(rdat),  32'(exp_rdata()));
  endtask

  // one cycle: drive at negedge, compare just after
  task automatic cyc(input logic w, input logic [DATA_W-1:0] d, input logic dn, input string tag);
    @(negedge clk);
    wr_en = w; wdat = d; done = dn;
    #1 cmp_model(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 sel", 32'(sel), 0);
    chk("R1 base", 32'(vbase), 0);
    chk("R1 rdata", 32'(rdat), 0);
    chk("R1 mask", 32'(mask), 0);

    // R2 / R5: arm without commit
    cyc(1'b1, 8'h02, 1'b0, "R2 arm");
    chk("R2 mask same cycle", 32'(mask), 1);
    for (int i = 0; i < WIN_CYC; i++) begin
      cyc(1'b0, '0, 1'b0, "R5 window");
      chk("R2 ce readback", 32'(rdat[CE_POS]), 1);
      chk("R5 mask held", 32'(mask), 1);
    end
    cyc(1'b0, '0, 1'b0, "R5 lapse");
    chk("R5 ce cleared", 32'(rdat[CE_POS]), 0);
    chk("R5 mask released", 32'(mask), 0);

    // R4: commit with no window
    cyc(1'b1, 8'h01, 1'b0, "R4 no window");
    cyc(1'b0, '0, 1'b0, "R4 after");
    chk("R4 sel unchanged", 32'(sel), 0);

    // R3 / R6 / R10: on-time commit, retire pulse in commit cycle is not enough
    cyc(1'b1, 8'h02, 1'b0, "R3 arm");
    idle(WIN_CYC - 1, "R3 wait");
    cyc(1'b1, 8'h01, 1'b1, "R3 commit last cycle");
    cyc(1'b0, '0, 1'b0, "R3 after");
    chk("R3 sel set", 32'(sel), 1);
    chk("R3 ce closed", 32'(rdat[CE_POS]), 0);
    chk("R10 base boot", 32'(vbase), 32'(BOOT_BASE));
    chk("R6 mask pending", 32'(mask), 1);
    idle(2, "R6 pending");
    chk("R6 mask still held", 32'(mask), 1);
    cyc(1'b0, '0, 1'b1, "R6 retire");
    chk("R6 mask during retire", 32'(mask), 1);
    cyc(1'b0, '0, 1'b0, "R6 released");
    chk("R6 mask released", 32'(mask), 0);

    // R4: one cycle late
    cyc(1'b1, 8'h02, 1'b0, "R4 arm");
    idle(WIN_CYC, "R4 wait");
    cyc(1'b1, 8'h00, 1'b0, "R4 late write");
    cyc(1'b0, '0, 1'b0, "R4 after late");
    chk("R4 late ignored", 32'(sel), 1);

    // R7: restart and double-bit write
    cyc(1'b1, 8'h02, 1'b0, "R7 arm");
    idle(WIN_CYC - 1, "R7 wait");
    cyc(1'b1, 8'h02, 1'b0, "R7 rearm");
    idle(WIN_CYC - 1, "R7 extended");
    chk("R7 window still open", 32'(rdat[CE_POS]), 1);
    cyc(1'b1, 8'h00, 1'b0, "R7 commit after restart");
    cyc(1'b0, '0, 1'b1, "R7 after");
    chk("R7 commit landed", 32'(sel), 0);
    cyc(1'b0, '0, 1'b0, "R7 settle");
    cyc(1'b1, 8'h02, 1'b0, "R7 arm2");
    cyc(1'b1, 8'h03, 1'b0, "R7 both bits");
    cyc(1'b0, '0, 1'b0, "R7 after both");
    chk("R7 both bits keep sel", 32'(sel), 0);
    chk("R7 both bits reopen", 32'(rdat[CE_POS]), 1);
    idle(WIN_CYC + 1, "R7 drain");

    // R8 / R9: all lock and region combinations, both placements
    for (int s = 0; s < 2; s++) begin
      if (s == 1) begin
        cyc(1'b1, 8'h02, 1'b0, "R8 arm");
        cyc(1'b1, 8'h01, 1'b0, "R8 commit");
        cyc(1'b0, '0, 1'b1, "R8 retire");
        cyc(1'b0, '0, 1'b0, "R8 settle");
      end
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        boot = k[0]; l_app = k[1]; l_boot = k[2];
        #1;
        chk(s ? "R8 lock mask" : "R9 lock mask", 32'(mask),
            32'((s == 1 && k[2] && !k[0]) || (s == 0 && k[1] && k[0])));
      end
      @(negedge clk);
      boot = 1'b0; l_app = 1'b0; l_boot = 1'b0;
    end

    // random traffic against the reference
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 2) == 0);
      wdat  = DATA_W'($urandom_range(0, 255));
      done  = ($urandom_range(0, 3) == 0);
      boot  = $urandom_range(0, 1) == 1;
      l_app = $urandom_range(0, 3) == 0;
      l_boot = $urandom_range(0, 3) == 0;
      #1 cmp_model("R3 R6 R7 R8 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule